// File: doc/BRIEF.md
# Two-wire bus slave with three-level strap addressing

This block is the target side of a two-wire serial bus (clock line plus open-drain data line). It watches both lines through synchronizers clocked by the system clock, recognises bus START and STOP conditions, and shifts in a 7-bit device address followed by a direction bit. If the address matches its own, it acknowledges. It then moves data bytes between the bus and a register file on the system side. Each data byte takes nine bus clocks: eight data bits and one acknowledge.

The device address is not programmed by software. Two strap inputs can each sit at one of three levels: tied low, left floating or tied high. Together they choose one of nine fixed addresses. The straps are captured once, on the first clock after reset is released. Later changes to the straps are ignored until the next reset.

On a write, the first data byte loads the register pointer. Every later byte of the same transfer is written to that pointer. On a read, each byte sent returns the register at the pointer. The master's acknowledge asks for another byte, and its not-acknowledge ends the read. The direction chosen after START stays in force until the next START.

Top module: `smb_strap_slave`

## Requirements
- R1: Strap levels are coded 2'b00 = low, 2'b01 = floating, 2'b10 = high; 2'b11 also counts as floating. The address is 7'h18, 7'h29 or 7'h4C for strap A low, floating or high. The level of strap B, counted 0, 1 or 2, is then added to that base, giving nine addresses.
- R2: The straps are captured on the first clock after reset is released. Changing them afterwards does not change which address is acknowledged.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Either one releases SDA at once. After STOP, bus clocks are ignored until a START arrives. A START or STOP in the middle of a byte abandons that byte.
- R4: After START, the first eight bits form the address byte, MSB first, with the direction bit last (0 = write, 1 = read). On a match, SDA is held low through the ninth clock. On a mismatch, SDA is not driven at all until the next START.
- R5: In a write, the first data byte is acknowledged and loaded into the register pointer, which appears on `reg_addr_o`. It causes no write strobe.
- R6: Each later write byte is acknowledged and produces exactly one `reg_wr_o` pulse, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte.
- R7: In a read, each byte is taken from `reg_rdata_i` at the pointer, with one `reg_rd_o` pulse per byte, and is sent MSB first. After each master acknowledge, the same pointer supplies the next byte.
- R8: A master not-acknowledge after a read byte ends the transfer. SDA stays released until the next START.
- R9: The direction is fixed until a START. A repeated START parses a new address byte, so a pointer write followed by a repeated-START read returns the selected register, and no write strobe occurs during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain) |
| strap_a_i | input | 2 | First address strap level (R1 coding) |
| strap_b_i | input | 2 | Second address strap level (R1 coding) |
| reg_addr_o | output | REG_AW | Register pointer |
| reg_wdata_o | output | 8 | Write data, valid with `reg_wr_o` |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register contents at `reg_addr_o` |
| reg_rd_o | output | 1 | One-cycle pulse when a read byte is loaded |

## Verification
Two functions can fall in the same cycle: START detection and data-bit shifting. When a repeated START follows a write acknowledge, the engine is already collecting the next data byte. It sees the SCL rise and then the falling SDA while SCL is high, so START must win and drop the partly shifted bit. The bench provokes this with a pointer write followed straight away by a repeated-START read. The check passes only if the read returns the register at the new pointer and no write strobe appears. STOP in the middle of a byte is provoked the same way. The check passes only if the next transfer treats its first data byte as a pointer again.

// File: rtl/smb_pkg.sv
package smb_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned DEV_W  = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDAT,
      ST_WACK,
      ST_RDAT,
      ST_RACK
   } eng_state_t;

   // low = 0, high = 2, anything else counts as floating = 1
   function automatic int unsigned strap_level(input logic [1:0] s);
      case (s)
         2'b00:   return 0;
         2'b10:   return 2;
         default: return 1;
      endcase
   endfunction

   function automatic logic [DEV_W-1:0] strap_to_addr(input logic [1:0] sa,
                                                      input logic [1:0] sb);
      logic [DEV_W-1:0] base;
      case (strap_level(sa))
         0:       base = 7'h18;
         1:       base = 7'h29;
         default: base = 7'h4C;
      endcase
      return base + DEV_W'(strap_level(sb));
   endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);

   logic [STAGES-1:0][WIDTH-1:0] chain;
   logic [WIDTH-1:0]             prev;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= d_i;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d_i};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= chain[STAGES-1];
   end

   assign q_o    = chain[STAGES-1];
   assign rise_o = chain[STAGES-1] & ~prev;
   assign fall_o = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/smb_strap_latch.sv
module smb_strap_latch
   import smb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       strap_a_i,
   input  logic [1:0]       strap_b_i,
   output logic [DEV_W-1:0] dev_addr_o,
   output logic             valid_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_addr_o <= '0;
         valid_o    <= 1'b0;
      end else if (!valid_o) begin
         dev_addr_o <= strap_to_addr(strap_a_i, strap_b_i);
         valid_o    <= 1'b1;
      end
   end

endmodule

// File: rtl/smb_engine.sv
module smb_engine
   import smb_pkg::*;
#(
   parameter int unsigned REG_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic              sda_rise,
   input  logic              sda_fall,
   input  logic [DEV_W-1:0]  dev_addr,
   input  logic              addr_valid,
   input  logic [BYTE_W-1:0] reg_rdata_i,
   output logic              sda_pull_o,
   output logic [REG_AW-1:0] reg_addr_o,
   output logic [BYTE_W-1:0] reg_wdata_o,
   output logic              reg_wr_o,
   output logic              reg_rd_o
);

   localparam int unsigned CNT_W = $clog2(BYTE_W + 1) + 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   eng_state_t        st;
   logic [BYTE_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              rw;
   logic              first;
   logic              bus_start, bus_stop;

   assign bus_start = scl_s & sda_fall;
   assign bus_stop  = scl_s & sda_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         sh          <= '0;
         cnt         <= '0;
         rw          <= 1'b0;
         first       <= 1'b1;
         sda_pull_o  <= 1'b0;
         reg_addr_o  <= '0;
         reg_wdata_o <= '0;
         reg_wr_o    <= 1'b0;
         reg_rd_o    <= 1'b0;
      end else begin
         reg_wr_o <= 1'b0;
         reg_rd_o <= 1'b0;
         if (bus_start) begin
            st         <= ST_ADDR;
            cnt        <= '0;
            first      <= 1'b1;
            sda_pull_o <= 1'b0;
         end else if (bus_stop) begin
            st         <= ST_IDLE;
            sda_pull_o <= 1'b0;
         end else begin
            case (st)
               ST_ADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     cnt <= '0;
                     if (addr_valid && sh[BYTE_W-1:1] == dev_addr) begin
                        st         <= ST_AACK;
                        sda_pull_o <= 1'b1;
                        rw         <= sh[0];
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_AACK, ST_WACK: begin
                  if (scl_rise) begin
                     cnt <= CNT_W'(1);
                  end else if (scl_fall && cnt == CNT_W'(1)) begin
                     cnt <= '0;
                     if (st == ST_AACK && rw) begin
                        st         <= ST_RDAT;
                        sh         <= reg_rdata_i;
                        sda_pull_o <= ~reg_rdata_i[BYTE_W-1];
                        reg_rd_o   <= 1'b1;
                     end else begin
                        st         <= ST_WDAT;
                        sda_pull_o <= 1'b0;
                     end
                  end
               end
               ST_WDAT: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     st         <= ST_WACK;
                     sda_pull_o <= 1'b1;
                     cnt        <= '0;
                     if (first) begin
                        reg_addr_o <= sh[REG_AW-1:0];
                        first      <= 1'b0;
                     end else begin
                        reg_wdata_o <= sh;
                        reg_wr_o    <= 1'b1;
                     end
                  end
               end
               ST_RDAT: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     st         <= ST_RACK;
                     sda_pull_o <= 1'b0;
                     cnt        <= '0;
                  end else if (scl_fall && cnt != '0) begin
                     sh         <= {sh[BYTE_W-2:0], 1'b0};
                     sda_pull_o <= ~sh[BYTE_W-2];
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     if (sda_s) st  <= ST_IDLE;
                     else       cnt <= CNT_W'(1);
                  end else if (scl_fall && cnt == CNT_W'(1)) begin
                     st         <= ST_RDAT;
                     cnt        <= '0;
                     sh         <= reg_rdata_i;
                     sda_pull_o <= ~reg_rdata_i[BYTE_W-1];
                     reg_rd_o   <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/smb_strap_slave.sv
module smb_strap_slave
   import smb_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REG_AW      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic [1:0]        strap_a_i,
   input  logic [1:0]        strap_b_i,
   output logic [REG_AW-1:0] reg_addr_o,
   output logic [7:0]        reg_wdata_o,
   output logic              reg_wr_o,
   input  logic [7:0]        reg_rdata_i,
   output logic              reg_rd_o
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (REG_AW < 1 || REG_AW > BYTE_W) begin : g_bad_aw
         $error("REG_AW must lie between 1 and 8");
      end
   endgenerate

   logic [1:0]       lines_s, lines_rise, lines_fall;
   logic             scl_s, sda_s, scl_rise, scl_fall, sda_rise, sda_fall;
   logic [DEV_W-1:0] dev_addr;
   logic             addr_valid;

   smb_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    ({scl_i, sda_i}),
      .q_o    (lines_s),
      .rise_o (lines_rise),
      .fall_o (lines_fall)
   );

   assign scl_s    = lines_s[1];
   assign sda_s    = lines_s[0];
   assign scl_rise = lines_rise[1];
   assign scl_fall = lines_fall[1];
   assign sda_rise = lines_rise[0];
   assign sda_fall = lines_fall[0];

   smb_strap_latch u_strap (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_a_i  (strap_a_i),
      .strap_b_i  (strap_b_i),
      .dev_addr_o (dev_addr),
      .valid_o    (addr_valid)
   );

   smb_engine #(.REG_AW(REG_AW)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_s       (scl_s),
      .scl_rise    (scl_rise),
      .scl_fall    (scl_fall),
      .sda_s       (sda_s),
      .sda_rise    (sda_rise),
      .sda_fall    (sda_fall),
      .dev_addr    (dev_addr),
      .addr_valid  (addr_valid),
      .reg_rdata_i (reg_rdata_i),
      .sda_pull_o  (sda_pull_o),
      .reg_addr_o  (reg_addr_o),
      .reg_wdata_o (reg_wdata_o),
      .reg_wr_o    (reg_wr_o),
      .reg_rd_o    (reg_rd_o)
   );

endmodule

// File: rtl/smb_strap_slave_chk.sv
module smb_strap_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       scl_fall,
   input logic       sda_rise,
   input logic       sda_fall,
   input logic [6:0] dev_addr,
   input logic       addr_valid,
   input logic       sda_pull_o,
   input logic       reg_wr_o,
   input logic       reg_rd_o,
   input logic [7:0] reg_rdata_i
);

   // R2: the captured address never moves once valid
   a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && $past(addr_valid)) |-> $stable(dev_addr));

   // R3: STOP releases the data line
   a_r3_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && sda_rise) |=> !sda_pull_o);

   // R3: START releases the data line
   a_r3_start_release: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && sda_fall) |=> !sda_pull_o);

   // R4: the data line only changes after an SCL fall or a START/STOP
   a_r4_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |-> $past(scl_fall || (scl_s && (sda_rise || sda_fall))));

   // R6: every write strobe comes with the acknowledge being driven
   a_r6_wr_acked: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |-> sda_pull_o);

   // R7: a loaded read byte immediately presents its MSB
   a_r7_rd_msb: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o |-> (sda_pull_o == !$past(reg_rdata_i[7])));

endmodule

bind smb_strap_slave smb_strap_slave_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_s       (scl_s),
   .scl_fall    (scl_fall),
   .sda_rise    (sda_rise),
   .sda_fall    (sda_fall),
   .dev_addr    (dev_addr),
   .addr_valid  (addr_valid),
   .sda_pull_o  (sda_pull_o),
   .reg_wr_o    (reg_wr_o),
   .reg_rd_o    (reg_rd_o),
   .reg_rdata_i (reg_rdata_i)
);

// File: tb/tb_smb_strap_slave.sv
module tb_smb_strap_slave;

   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_bus;
   logic       sda_pull;
   logic [1:0] sa = 2'b00, sb = 2'b00;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic       reg_wr, reg_rd;

   logic [7:0] mem   [256];
   logic [7:0] model [256];
   logic [15:0] exp_wr_q [$];
   int total = 0, bad = 0, wr_seen = 0, rd_seen = 0;
   bit done = 0;

   always #10 clk = ~clk;

   assign sda_bus   = sda_m & ~sda_pull;
   assign reg_rdata = mem[reg_addr];

   smb_strap_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_pull_o(sda_pull), .strap_a_i(sa), .strap_b_i(sb),
      .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_wr_o(reg_wr),
      .reg_rdata_i(reg_rdata), .reg_rd_o(reg_rd)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference monitor, every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (reg_wr) begin
            wr_seen++;
            if (exp_wr_q.size() == 0) begin
               chk(0, "R6 unexpected write strobe", {reg_addr, reg_wdata}, 0);
            end else begin
               logic [15:0] e;
               e = exp_wr_q.pop_front();
               chk({reg_addr, reg_wdata} == e, "R6 write addr/data", {reg_addr, reg_wdata}, e);
            end
            mem[reg_addr] = reg_wdata;
         end
         if (reg_rd) rd_seen++;
      end
   end

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic clock_bit(input logic b, output logic s);
      sda_m = b; wq();
      scl_m = 1'b1; wq();
      s = sda_bus; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic write_byte(input logic [7:0] d, output bit acked);
      logic s;
      for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
      clock_bit(1'b1, s);
      acked = !s;
   endtask

   task automatic read_byte(input bit give_ack, output logic [7:0] d);
      logic s;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         clock_bit(1'b1, s);
         d = {d[6:0], s};
      end
      clock_bit(!give_ack, s);
   endtask

   task automatic do_reset(input logic [1:0] a, input logic [1:0] b);
      rst_n = 1'b0; sa = a; sb = b; scl_m = 1'b1; sda_m = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [6:0] ref_addr(input logic [1:0] a, input logic [1:0] b);
      int la, lb;
      la = (a == 2'b00) ? 0 : (a == 2'b10) ? 2 : 1;
      lb = (b == 2'b00) ? 0 : (b == 2'b10) ? 2 : 1;
      case (la)
         0: return 7'(24 + lb);
         1: return 7'(41 + lb);
         default: return 7'(76 + lb);
      endcase
   endfunction

   task automatic probe(input logic [6:0] a, input bit exp_ack, input string req);
      bit ak;
      bus_start();
      write_byte({a, 1'b0}, ak);
      bus_stop();
      chk(ak == exp_ack, req, ak, exp_ack);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [1:0] lv [3];
      logic [6:0] A;
      logic [7:0] d;
      bit ak;
      logic s;
      int w0, r0;
      lv[0] = 2'b00; lv[1] = 2'b01; lv[2] = 2'b10;
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i * 37 + 5);
         model[i] = 8'(i * 37 + 5);
      end

      // reset state
      do_reset(2'b01, 2'b10);
      chk(sda_pull == 1'b0, "R3 reset releases SDA", sda_pull, 0);
      chk(reg_wr == 1'b0 && reg_rd == 1'b0, "R3 reset no strobes", {reg_wr, reg_rd}, 0);

      // R1: all nine strap combinations plus the 2'b11 floating code
      for (int i = 0; i < 3; i++) begin
         for (int j = 0; j < 3; j++) begin
            do_reset(lv[i], lv[j]);
            probe(ref_addr(lv[i], lv[j]), 1, "R1 own address acked");
            probe(ref_addr(lv[i], lv[j]) ^ 7'h40, 0, "R1 foreign address ignored");
         end
      end
      do_reset(2'b11, 2'b11);
      probe(7'h2A, 1, "R1 code 11 counts as floating");

      // R2: straps frozen after capture
      do_reset(2'b01, 2'b10);
      A = 7'h2B;
      sa = 2'b00; sb = 2'b00;
      repeat (4) @(negedge clk);
      probe(7'h18, 0, "R2 new strap value ignored");
      probe(A, 1, "R2 captured address kept");

      // R5 / R6: pointer then two data bytes
      w0 = wr_seen;
      bus_start();
      write_byte({A, 1'b0}, ak); chk(ak, "R4 address ack", ak, 1);
      write_byte(8'h10, ak);     chk(ak, "R5 pointer ack", ak, 1);
      exp_wr_q.push_back({8'h10, 8'hA5});
      write_byte(8'hA5, ak);     chk(ak, "R6 data ack", ak, 1);
      exp_wr_q.push_back({8'h10, 8'h5A});
      write_byte(8'h5A, ak);     chk(ak, "R6 second data ack", ak, 1);
      bus_stop();
      model[8'h10] = 8'h5A;
      chk(wr_seen - w0 == 2, "R6 strobe count", wr_seen - w0, 2);
      chk(exp_wr_q.size() == 0, "R6 all writes seen", exp_wr_q.size(), 0);

      w0 = wr_seen;
      bus_start();
      write_byte({A, 1'b0}, ak);
      write_byte(8'h22, ak);
      bus_stop();
      chk(reg_addr == 8'h22, "R5 pointer on reg_addr_o", reg_addr, 8'h22);
      chk(wr_seen == w0, "R5 pointer byte has no strobe", wr_seen - w0, 0);

      // R7 / R9: pointer write, repeated START, three-byte read
      w0 = wr_seen; r0 = rd_seen;
      bus_start();
      write_byte({A, 1'b0}, ak);
      write_byte(8'h10, ak);
      bus_start();
      write_byte({A, 1'b1}, ak); chk(ak, "R9 repeated START read ack", ak, 1);
      read_byte(1, d); chk(d == model[8'h10], "R7 read byte 1", d, model[8'h10]);
      read_byte(1, d); chk(d == model[8'h10], "R7 read byte 2", d, model[8'h10]);
      read_byte(0, d); chk(d == model[8'h10], "R7 read byte 3", d, model[8'h10]);
      bus_stop();
      chk(rd_seen - r0 == 3, "R7 read strobe count", rd_seen - r0, 3);
      chk(wr_seen == w0, "R9 no write during read", wr_seen - w0, 0);
      chk(reg_addr == 8'h10, "R9 pointer from repeated START", reg_addr, 8'h10);

      // R8: NAK releases SDA
      r0 = rd_seen;
      bus_start();
      write_byte({A, 1'b0}, ak);
      write_byte(8'h22, ak);
      bus_start();
      write_byte({A, 1'b1}, ak);
      read_byte(0, d); chk(d == model[8'h22], "R7 read other pointer", d, model[8'h22]);
      read_byte(1, d); chk(d == 8'hFF, "R8 SDA released after NAK", d, 8'hFF);
      bus_stop();
      chk(rd_seen - r0 == 1, "R8 no reload after NAK", rd_seen - r0, 1);

      // R4: mismatch drives nothing
      w0 = wr_seen;
      bus_start();
      write_byte({7'h18, 1'b0}, ak); chk(!ak, "R4 mismatch no ack", ak, 0);
      write_byte(8'h00, ak);         chk(!ak, "R4 mismatch silent", ak, 0);
      bus_stop();
      chk(wr_seen == w0, "R4 mismatch no strobe", wr_seen - w0, 0);

      // R3: bus clocks without START are ignored
      scl_m = 1'b0; wq();
      write_byte({A, 1'b0}, ak); chk(!ak, "R3 no response without START", ak, 0);
      bus_stop();

      // R3: STOP mid-byte abandons it; next first byte is a pointer again
      w0 = wr_seen;
      bus_start();
      write_byte({A, 1'b0}, ak);
      write_byte(8'h40, ak);
      for (int i = 0; i < 4; i++) clock_bit(1'b1, s);
      bus_stop();
      bus_start();
      write_byte({A, 1'b0}, ak); chk(ak, "R3 recovers after STOP", ak, 1);
      write_byte(8'h30, ak);
      bus_stop();
      chk(reg_addr == 8'h30, "R3 fresh pointer after STOP", reg_addr, 8'h30);
      chk(wr_seen == w0, "R3 abandoned byte not written", wr_seen - w0, 0);

      repeat (10) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule